// File: doc/BRIEF.md
# Vector Partial-Sum Reduction Unit

This block adds up a stream of integer elements of arbitrary length. Elements arrive as chunks of `VL` lanes. Each accepted chunk is added lane by lane into a bank of `VL` partial sums. The bank starts from zero.

When the chunk flagged as last has been absorbed, the block collapses the bank in place. Each cycle it halves the live portion by folding its upper half onto its lower half. After `log2(VL)` such steps a single total is left in lane 0. That total is presented for one cycle, and the bank is then wiped for the next stream.

A count input tells the block how many of the low lanes in a chunk carry real data. A short final chunk therefore needs no zero padding from the source. All arithmetic is integer addition that wraps modulo 2^W. The total therefore equals what a plain serial loop would produce with the same wraparound.

Top module: `vec_reduce_sum`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` and `out_sum` are 0. A reset in the middle of a stream discards every partial sum gathered so far.
- R2: Lane j of a chunk occupies `in_data[j*W +: W]`. Every accepted chunk is added lane-wise into the partial-sum bank, so the reported total equals the sum of all accepted elements of the stream.
- R3: `in_cnt` gives how many low lanes of a chunk are valid, on every beat. Lanes with index `>= in_cnt` count as zero, and any `in_cnt >= VL` means the full chunk.
- R4: When the beat with `in_last` is taken at rising edge E, `out_valid` rises on edge E+log2(VL). Every halving step takes one cycle.
- R5: `out_valid` is high for exactly one cycle per stream. `out_sum` reads 0 whenever `out_valid` is low.
- R6: Sums wrap modulo 2^W.
- R7: Beats offered during the halving steps or the result cycle, including ones with `in_last`, are dropped. They neither enter the current total nor start or seed another stream.
- R8: After the result cycle the bank is zero. The next stream's total contains nothing from the previous one.
- R9: A stream may consist of a single last chunk. `in_last` while `in_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A chunk is present on `in_data` this cycle |
| in_last | input | 1 | This chunk closes the stream |
| in_cnt | input | CW | Number of valid low lanes (CW = clog2(VL+1)) |
| in_data | input | VL*W | Chunk, lane j at bits j*W +: W |
| out_valid | output | 1 | One-cycle strobe for the total |
| out_sum | output | W | Stream total while `out_valid`, else 0 |

## Verification
The bench goes after short final chunks, including a count of zero and a count above `VL`. A design that ignored the count would add stale upper lanes into the total. Streams are chosen to overflow W bits, which a widened or saturating adder would get wrong.

The bench also floods the input with last-flagged junk while the tree collapses. A block that kept listening would corrupt the total, fire a second result, or leak junk into the next stream.

A reset mid-stream and back-to-back streams expose a bank that is not cleared. The exact position of the strobe catches a fold count that is off by one, because such a count would report lane 0 before or after it holds the full total.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    typedef enum logic [1:0] {
        ST_ACC  = 2'd0,
        ST_FOLD = 2'd1,
        ST_DONE = 2'd2
    } vrs_state_e;

    // A lane holds real data when its index is below the beat count.
    function automatic logic lane_kept(input int lane, input int cnt);
        return lane < cnt;
    endfunction

endpackage

// File: rtl/vrs_lane_mask.sv
module vrs_lane_mask
    import vrs_pkg::*;
#(
    parameter int W  = 16,
    parameter int VL = 8,
    parameter int CW = $clog2(VL + 1)
) (
    input  logic [VL*W-1:0] chunk_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [VL*W-1:0] chunk_o
);

    for (genvar j = 0; j < VL; j++) begin : g_lane
        always_comb begin
            if (lane_kept(j, int'(cnt_i)))
                chunk_o[j*W +: W] = chunk_i[j*W +: W];
            else
                chunk_o[j*W +: W] = '0;
        end
    end

endmodule

// File: rtl/vrs_fold_ctrl.sv
module vrs_fold_ctrl
    import vrs_pkg::*;
#(
    parameter int VL = 8,
    parameter int HW = $clog2(VL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_i,
    input  logic          last_i,
    output logic          acc_en_o,
    output logic          fold_en_o,
    output logic          done_o,
    output logic [HW-1:0] fold_half_o
);

    localparam int STEPS = $clog2(VL);

    vrs_state_e    state_q;
    logic [HW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACC;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_ACC: begin
                    if (beat_i && last_i) begin
                        state_q <= ST_FOLD;
                        step_q  <= '0;
                    end
                end
                ST_FOLD: begin
                    if (step_q == HW'(STEPS - 1))
                        state_q <= ST_DONE;
                    else
                        step_q <= step_q + 1'b1;
                end
                default: state_q <= ST_ACC;
            endcase
        end
    end

    always_comb begin
        acc_en_o    = (state_q == ST_ACC) && beat_i;
        fold_en_o   = (state_q == ST_FOLD);
        done_o      = (state_q == ST_DONE);
        fold_half_o = HW'(VL >> (int'(step_q) + 1));
    end

endmodule

// File: rtl/vrs_partial_bank.sv
module vrs_partial_bank #(
    parameter int W  = 16,
    parameter int VL = 8,
    parameter int HW = $clog2(VL)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            acc_en_i,
    input  logic [VL*W-1:0] add_i,
    input  logic            fold_en_i,
    input  logic [HW-1:0]   fold_half_i,
    output logic [W-1:0]    lane0_o
);

    logic [W-1:0] part_q [VL];

    for (genvar i = 0; i < VL; i++) begin : g_part
        logic [W-1:0] partner;

        always_comb begin
            partner = '0;
            for (int k = 0; k < VL; k++) begin
                if (k == i + int'(fold_half_i))
                    partner = part_q[k];
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clr_i)
                part_q[i] <= '0;
            else if (acc_en_i)
                part_q[i] <= part_q[i] + add_i[i*W +: W];
            else if (fold_en_i && (i < int'(fold_half_i)))
                part_q[i] <= part_q[i] + partner;
        end
    end

    assign lane0_o = part_q[0];

endmodule

// File: rtl/vec_reduce_sum.sv
module vec_reduce_sum #(
    parameter int W  = 16,
    parameter int VL = 8,
    parameter int CW = $clog2(VL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic [CW-1:0]   in_cnt,
    input  logic [VL*W-1:0] in_data,
    output logic            out_valid,
    output logic [W-1:0]    out_sum
);

    localparam int HW = $clog2(VL);

    logic [VL*W-1:0] masked;
    logic            acc_en;
    logic            fold_en;
    logic            done;
    logic [HW-1:0]   fold_half;
    logic [W-1:0]    lane0;

    vrs_lane_mask #(.W(W), .VL(VL), .CW(CW)) u_mask (
        .chunk_i (in_data),
        .cnt_i   (in_cnt),
        .chunk_o (masked)
    );

    vrs_fold_ctrl #(.VL(VL), .HW(HW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .beat_i      (in_valid),
        .last_i      (in_last),
        .acc_en_o    (acc_en),
        .fold_en_o   (fold_en),
        .done_o      (done),
        .fold_half_o (fold_half)
    );

    vrs_partial_bank #(.W(W), .VL(VL), .HW(HW)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (done),
        .acc_en_i    (acc_en),
        .add_i       (masked),
        .fold_en_i   (fold_en),
        .fold_half_i (fold_half),
        .lane0_o     (lane0)
    );

    assign out_valid = done;
    assign out_sum   = done ? lane0 : '0;

endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
    parameter int W  = 16,
    parameter int VL = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_last,
    input logic         out_valid,
    input logic [W-1:0] out_sum
);

    localparam int STEPS = $clog2(VL);

    logic       pend_q;
    logic [7:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!pend_q) begin
            if (in_valid && in_last) begin
                pend_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (out_valid) begin
            pend_q <= 1'b0;
        end else if (cnt_q != 8'hFF) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RESULT_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cnt_q == 8'(STEPS)) |-> out_valid); // R4
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend_q && cnt_q == 8'(STEPS))); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R5
    AST_SUM_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_sum == '0)); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sum == '0)); // R1

endmodule

bind vec_reduce_sum vrs_checker #(.W(W), .VL(VL)) u_vrs_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/test_vec_reduce_sum.sv
`timescale 1ns/1ps
module test_vec_reduce_sum;

    localparam int W   = 16;
    localparam int VL  = 8;
    localparam int CW  = $clog2(VL + 1);
    localparam int LAT = $clog2(VL) + 1;   // negedges counted after the last beat
    localparam int NROW = 11;

    // row: {last, cnt, base, step}; lane j = base + j*step
    localparam logic [1+CW+2*W-1:0] TBL [NROW] = '{
        {1'b0, 4'd8,  16'h0001, 16'h0001},
        {1'b1, 4'd8,  16'h0064, 16'h0003},
        {1'b1, 4'd8,  16'hFFF0, 16'h1111},
        {1'b0, 4'd8,  16'h0005, 16'h0002},
        {1'b1, 4'd3,  16'h0007, 16'h0100},
        {1'b1, 4'd0,  16'h007B, 16'h0004},
        {1'b0, 4'd8,  16'h8000, 16'h0000},
        {1'b0, 4'd5,  16'h7FFF, 16'h0001},
        {1'b1, 4'd12, 16'h0002, 16'hFFFF},
        {1'b0, 4'd2,  16'h0009, 16'h0009},
        {1'b1, 4'd8,  16'h0000, 16'h0000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_last = 1'b0;
    logic [CW-1:0]   in_cnt = '0;
    logic [VL*W-1:0] in_data = '0;
    logic            out_valid;
    logic [W-1:0]    out_sum;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vec_reduce_sum #(.W(W), .VL(VL)) i_vec_reduce_sum (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_cnt    (in_cnt),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [VL*W-1:0] mk(input logic [W-1:0] base, input logic [W-1:0] step);
        logic [VL*W-1:0] d;
        for (int j = 0; j < VL; j++) d[j*W +: W] = base + W'(j) * step;
        return d;
    endfunction

    function automatic logic [W-1:0] ref_sum(input logic [VL*W-1:0] d, input int cnt);
        logic [W-1:0] s = '0;
        for (int j = 0; j < VL; j++) if (j < cnt) s = s + d[j*W +: W];
        return s;
    endfunction

    // Called at a negedge; returns at the negedge after the sampling edge.
    task automatic put_beat(input logic [VL*W-1:0] d, input int cnt, input logic last);
        in_valid = 1'b1;
        in_last  = last;
        in_cnt   = CW'(cnt);
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic get_result(output logic [W-1:0] s, output int lat);
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        s = out_sum;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] acc;
        logic [W-1:0] got;
        int           lat;

        // R1: idle outputs during and right after reset
        repeat (3) @(negedge clk);
        check(!out_valid && out_sum == '0, "R1 reset outputs", {out_valid, out_sum}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_sum == '0, "R1 after reset", {out_valid, out_sum}, 0);

        // R2 R3 R6 R8: table-driven streams
        acc = '0;
        for (int r = 0; r < NROW; r++) begin
            logic          lst;
            logic [CW-1:0] c;
            logic [W-1:0]  b, st;
            logic [VL*W-1:0] d;
            {lst, c, b, st} = TBL[r];
            d   = mk(b, st);
            acc = acc + ref_sum(d, int'(c));
            put_beat(d, int'(c), lst);
            if (lst) begin
                get_result(got, lat);
                check(lat == LAT, "R4 latency", lat, LAT);
                check(got == acc, "R2 R3 R6 R8 stream total", got, acc);
                @(negedge clk);
                check(!out_valid && out_sum == '0, "R5 one-cycle strobe", {out_valid, out_sum}, 0);
                acc = '0;
            end
        end

        // R7: junk with in_last during folding and result cycle is dropped
        begin
            logic [VL*W-1:0] d = mk(16'h0101, 16'h0202);
            logic [W-1:0] exp = ref_sum(d, VL);
            in_valid = 1'b1; in_last = 1'b1; in_cnt = CW'(VL); in_data = d;
            @(negedge clk);
            in_data = mk(16'hDEAD, 16'h0F0F);
            lat = 1;
            while (!out_valid && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            got = out_sum;
            check(lat == LAT, "R7 latency under junk", lat, LAT);
            check(got == exp, "R7 total under junk", got, exp);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            check(!out_valid, "R7 no second result", out_valid, 0);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check(!out_valid, "R7 junk started no stream", out_valid, 0);
            end
            d = mk(16'h0003, 16'h0001);
            put_beat(d, VL, 1'b1);
            get_result(got, lat);
            exp = ref_sum(d, VL);
            check(got == exp, "R7 R8 no junk carried", got, exp);
            @(negedge clk);
        end

        // R9: in_last without in_valid does nothing
        in_last = 1'b1;
        in_data = mk(16'h1234, 16'h1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!out_valid, "R9 last without valid", out_valid, 0);
        end
        in_last = 1'b0;
        begin
            logic [VL*W-1:0] d = mk(16'h0010, 16'h0010);
            put_beat(d, VL, 1'b1);
            get_result(got, lat);
            check(got == ref_sum(d, VL), "R9 single chunk after idle last", got, ref_sum(d, VL));
            @(negedge clk);
        end

        // R1: reset mid-stream discards gathered partials
        put_beat(mk(16'h7777, 16'h1111), VL, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && out_sum == '0, "R1 reset mid-stream outputs", {out_valid, out_sum}, 0);
        rst = 1'b0;
        @(negedge clk);
        begin
            logic [VL*W-1:0] d = mk(16'h0002, 16'h0000);
            put_beat(d, VL, 1'b1);
            get_result(got, lat);
            check(got == 16'h0010, "R1 partials cleared by reset", got, 16'h0010);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule